// File: doc/BRIEF.md
# I/O Translation Unit Register Block

This block is the software-visible register set of an I/O address translation unit. A host reaches it through a plain word-wide bus. Each write and each read lasts one cycle. Each register keeps only the bits its write mask lets through, and some registers add bits that are always set. The block gives the translation datapath three values: the enable bit, the page-table base, and the start address of the translated DVMA window. That start address is decoded from the size code in the control register.

The translation datapath reports faults through a one-cycle capture pulse. The pulse carries a status word and a faulting address, and it raises the interrupt line. Software clears the interrupt in one of two ways. It can read either fault register, or it can write either fault register.

The block holds state only. It does not walk page tables, flush cached translations or arbitrate the bus.

Top module: `iomap_regs`

## Requirements
- R1: After reset, every register reads as zero except these: control = VERSION in bits 31:24, fault status = 0x00800000, arbiter enable = 0x00000003, arbitration enable = 0x00000008 and mask ID = 0x23000000. After reset, win_start = 0 and irq = 0.
- R2: A write to control (byte offset 0x0000) stores (data & 0x1D) | (VERSION << 24). Bit 0 of control drives xlate_enable.
- R3: A write to control with size code n = data[4:2] sets win_start to 0xFFFFFFFF shifted left by 24+n bits. So n=0 gives 0xFF000000 and n=7 gives 0x80000000. win_start changes on no other event.
- R4: A write to the base register (0x0004) stores data & 0x07FFFC00. That value appears on xlate_base.
- R5: A write to arbiter enable (0x1008) stores (data & 0x801F000F) | 1. A write to any of the four slot-config registers at 0x1010, 0x1014, 0x1018 and 0x101C stores data & 0x00010003.
- R6: A write to fault status (0x1000) stores (data & 0xFF0FFFFF) | 0x00800000. A write to fault address (0x1004) stores the whole word. Either write lowers irq on the next cycle.
- R7: A read of fault status or fault address returns its contents and lowers irq on the next cycle.
- R8: A write to arbitration enable (0x2000) stores (data & 0x001F0000) | 0x8. A write to mask ID (0x3018) ORs data & 0x00FFFFFF into the current value.
- R9: The TLB-flush register (0x0014) and the page-flush register (0x0018) each store the full written word.
- R10: A fault_set pulse has three effects. Fault status becomes fault_status | 0x00800000, fault address becomes fault_addr, and irq rises on the next cycle. All three win over a bus write to the same register and over an irq clear in the same cycle.
- R11: A read of an offset not listed above returns 0. A write to such an offset changes no register.
- R12: Byte offsets are decoded on bits 13:2, so each register occupies one 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 14 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from current state) |
| fault_set | input | 1 | Fault capture pulse from the translation datapath |
| fault_status | input | 32 | Status word captured on fault_set |
| fault_addr | input | 32 | Address captured on fault_set |
| irq | output | 1 | Fault interrupt |
| xlate_enable | output | 1 | Translation enable (control bit 0) |
| xlate_base | output | 32 | Masked page-table base |
| win_start | output | 32 | DVMA window start address |

## Verification
Directed writes of all-ones and all-zeros data to every register separate a mask that keeps too much from one that keeps too little, and they show forced bits that are missing. Every one of the eight size codes is written, so a wrong shift on any single code shows up on win_start. Fault pulses are sent alone, together with a fault-register write, and together with a fault-register read; this separates set-over-clear priority from clear-over-set priority. A long random phase then mixes writes and reads to implemented and unimplemented offsets with random fault pulses. Its aim is to expose decode aliasing and any side effect on a neighbouring register.

// File: rtl/iomap_pkg.sv
package iomap_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned IDX_W   = 12;
    localparam int unsigned SLOT_N  = 4;

    // Word indices (byte offset >> 2)
    localparam logic [IDX_W-1:0] IX_CTRL   = 12'h000;
    localparam logic [IDX_W-1:0] IX_BASE   = 12'h001;
    localparam logic [IDX_W-1:0] IX_TLBF   = 12'h005;
    localparam logic [IDX_W-1:0] IX_PGF    = 12'h006;
    localparam logic [IDX_W-1:0] IX_FSR    = 12'h400;
    localparam logic [IDX_W-1:0] IX_FAR    = 12'h401;
    localparam logic [IDX_W-1:0] IX_AER    = 12'h402;
    localparam logic [IDX_W-1:0] IX_SLOT0  = 12'h404;
    localparam logic [IDX_W-1:0] IX_ARBEN  = 12'h800;
    localparam logic [IDX_W-1:0] IX_MASKID = 12'hC06;

    localparam logic [WORD_W-1:0] M_CTRL   = 32'h0000_001D;
    localparam logic [WORD_W-1:0] M_BASE   = 32'h07FF_FC00;
    localparam logic [WORD_W-1:0] M_FSR    = 32'hFF0F_FFFF;
    localparam logic [WORD_W-1:0] F_FSR    = 32'h0080_0000;
    localparam logic [WORD_W-1:0] M_AER    = 32'h801F_000F;
    localparam logic [WORD_W-1:0] F_AER    = 32'h0000_0001;
    localparam logic [WORD_W-1:0] M_SLOT   = 32'h0001_0003;
    localparam logic [WORD_W-1:0] M_ARBEN  = 32'h001F_0000;
    localparam logic [WORD_W-1:0] F_ARBEN  = 32'h0000_0008;
    localparam logic [WORD_W-1:0] M_MASKID = 32'h00FF_FFFF;

    localparam logic [WORD_W-1:0] RST_AER    = 32'h0000_0003;
    localparam logic [WORD_W-1:0] RST_MASKID = 32'h2300_0000;

    typedef struct packed {
        logic              ctrl;
        logic              base;
        logic              tlbf;
        logic              pgf;
        logic              fsr;
        logic              fadr;
        logic              aer;
        logic              arben;
        logic              maskid;
        logic [SLOT_N-1:0] slot;
    } sel_t;
endpackage

// File: rtl/iomap_decode.sv
module iomap_decode
    import iomap_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    localparam int W = ADDR_W - 2;

    logic [W-1:0]      idx;
    logic [SLOT_N-1:0] slot_hit;

    assign idx = addr[ADDR_W-1:2];

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        assign slot_hit[g] = (idx == W'(IX_SLOT0 + IDX_W'(g)));
    end

    always_comb begin
        sel.ctrl   = (idx == W'(IX_CTRL));
        sel.base   = (idx == W'(IX_BASE));
        sel.tlbf   = (idx == W'(IX_TLBF));
        sel.pgf    = (idx == W'(IX_PGF));
        sel.fsr    = (idx == W'(IX_FSR));
        sel.fadr   = (idx == W'(IX_FAR));
        sel.aer    = (idx == W'(IX_AER));
        sel.arben  = (idx == W'(IX_ARBEN));
        sel.maskid = (idx == W'(IX_MASKID));
        sel.slot   = slot_hit;
    end
endmodule

// File: rtl/iomap_window.sv
module iomap_window #(
    parameter int VA_W     = 32,
    parameter int MIN_LOG2 = 24,
    parameter int CODE_W   = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [VA_W-1:0]   start
);
    localparam int SH_W = $clog2(VA_W) + 1;

    logic [SH_W-1:0] shamt;

    always_comb begin
        shamt = SH_W'(MIN_LOG2) + SH_W'(code);
        start = {VA_W{1'b1}} << shamt;
    end
endmodule

// File: rtl/iomap_irq.sv
module iomap_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr) irq_d = 1'b0;
        if (set) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/iomap_regs.sv
module iomap_regs
    import iomap_pkg::*;
#(
    parameter int         ADDR_W  = 14,
    parameter logic [7:0] VERSION = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fault_set,
    input  logic [31:0]       fault_status,
    input  logic [31:0]       fault_addr,
    output logic              irq,
    output logic              xlate_enable,
    output logic [31:0]       xlate_base,
    output logic [31:0]       win_start
);
    localparam logic [31:0] VER_WORD = {VERSION, 24'h0};

    typedef struct packed {
        logic [31:0]              ctrl;
        logic [31:0]              base;
        logic [31:0]              tlbf;
        logic [31:0]              pgf;
        logic [31:0]              fsr;
        logic [31:0]              fadr;
        logic [31:0]              aer;
        logic [31:0]              arben;
        logic [31:0]              maskid;
        logic [31:0]              win;
        logic [SLOT_N-1:0][31:0]  slot;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r        = '0;
        r.ctrl   = VER_WORD;
        r.fsr    = F_FSR;
        r.aer    = RST_AER;
        r.arben  = F_ARBEN;
        r.maskid = RST_MASKID;
        return r;
    endfunction

    sel_t        sel;
    regs_t       r_d, r_q;
    logic [31:0] win_next;
    logic        irq_clr;

    iomap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    iomap_window #(.VA_W(32), .MIN_LOG2(24), .CODE_W(3)) u_window (
        .code  (bus_wdata[4:2]),
        .start (win_next)
    );

    assign irq_clr = (bus_wr_en || bus_rd_en) && (sel.fsr || sel.fadr);

    iomap_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fault_set),
        .clr   (irq_clr),
        .irq   (irq)
    );

    always_comb begin
        r_d = r_q;
        if (bus_wr_en) begin
            if (sel.ctrl) begin
                r_d.ctrl = (bus_wdata & M_CTRL) | VER_WORD;
                r_d.win  = win_next;
            end
            if (sel.base)   r_d.base   = bus_wdata & M_BASE;
            if (sel.tlbf)   r_d.tlbf   = bus_wdata;
            if (sel.pgf)    r_d.pgf    = bus_wdata;
            if (sel.fsr)    r_d.fsr    = (bus_wdata & M_FSR) | F_FSR;
            if (sel.fadr)   r_d.fadr   = bus_wdata;
            if (sel.aer)    r_d.aer    = (bus_wdata & M_AER) | F_AER;
            if (sel.arben)  r_d.arben  = (bus_wdata & M_ARBEN) | F_ARBEN;
            if (sel.maskid) r_d.maskid = r_q.maskid | (bus_wdata & M_MASKID);
            for (int i = 0; i < SLOT_N; i++) begin
                if (sel.slot[i]) r_d.slot[i] = bus_wdata & M_SLOT;
            end
        end
        // Capture from the translation datapath wins over the bus
        if (fault_set) begin
            r_d.fsr  = fault_status | F_FSR;
            r_d.fadr = fault_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= reset_regs();
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.ctrl)   bus_rdata = r_q.ctrl;
        if (sel.base)   bus_rdata = r_q.base;
        if (sel.tlbf)   bus_rdata = r_q.tlbf;
        if (sel.pgf)    bus_rdata = r_q.pgf;
        if (sel.fsr)    bus_rdata = r_q.fsr;
        if (sel.fadr)   bus_rdata = r_q.fadr;
        if (sel.aer)    bus_rdata = r_q.aer;
        if (sel.arben)  bus_rdata = r_q.arben;
        if (sel.maskid) bus_rdata = r_q.maskid;
        for (int i = 0; i < SLOT_N; i++) begin
            if (sel.slot[i]) bus_rdata = r_q.slot[i];
        end
    end

    assign xlate_enable = r_q.ctrl[0];
    assign xlate_base   = r_q.base;
    assign win_start    = r_q.win;
endmodule

// File: rtl/iomap_regs_chk.sv
module iomap_regs_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              fault_set,
    input logic              irq,
    input logic              xlate_enable,
    input logic [31:0]       xlate_base,
    input logic [31:0]       win_start
);
    logic hit_fault, hit_ctrl;
    assign hit_fault = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(12'h400)) ||
                       (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(12'h401));
    assign hit_ctrl  = (bus_addr[ADDR_W-1:2] == '0);

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> irq);

    assert_irq_rdclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && hit_fault && !fault_set) |=> !irq);

    assert_irq_wrclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_fault && !fault_set) |=> !irq);

    assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_ctrl) |=> (xlate_enable == $past(bus_wdata[0])));

    assert_win_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && hit_ctrl) |=> $stable(win_start));

    assert_win_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start != 32'h0) |-> (win_start[31] && win_start[23:0] == 24'h0));

    assert_base_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_base & ~32'h07FF_FC00) == 32'h0);
endmodule

bind iomap_regs iomap_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .fault_set    (fault_set),
    .irq          (irq),
    .xlate_enable (xlate_enable),
    .xlate_base   (xlate_base),
    .win_start    (win_start)
);

// File: tb/tb_iomap_regs.sv
`timescale 1ns/100ps
module tb_iomap_regs;
    localparam logic [7:0] VER = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, fs = 1'b0;
    logic [13:0] addr = '0;
    logic [31:0] wdata = '0, fstat = '0, faddr = '0;
    logic [31:0] rdata, xbase, wstart;
    logic        irq, xen;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    iomap_regs #(.ADDR_W(14), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .fault_set(fs), .fault_status(fstat), .fault_addr(faddr),
        .irq(irq), .xlate_enable(xen), .xlate_base(xbase), .win_start(wstart)
    );

    // ---------------- reference model ----------------
    logic [31:0] mreg [int];
    logic [31:0] mwin;
    logic        mirq;

    function automatic logic [31:0] mread(int off);
        if (mreg.exists(off)) return mreg[off];
        return 32'h0;
    endfunction

    task automatic model_reset();
        mreg.delete();
        mreg[32'h0000] = {VER, 24'h0};
        mreg[32'h0004] = 0; mreg[32'h0014] = 0; mreg[32'h0018] = 0;
        mreg[32'h1000] = 32'h0080_0000; mreg[32'h1004] = 0;
        mreg[32'h1008] = 32'h3;
        for (int k = 0; k < 4; k++) mreg[32'h1010 + 4*k] = 0;
        mreg[32'h2000] = 32'h8;
        mreg[32'h3018] = 32'h2300_0000;
        mwin = 0;
        mirq = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int off;
            off = int'(addr);
            if (wr) begin
                case (off)
                    32'h0000: begin
                        mreg[off] = (wdata & 32'h1D) | {VER, 24'h0};
                        mwin = 32'hFFFF_FFFF << (24 + int'(wdata[4:2]));
                    end
                    32'h0004: mreg[off] = wdata & 32'h07FF_FC00;
                    32'h0014, 32'h0018, 32'h1004: mreg[off] = wdata;
                    32'h1000: mreg[off] = (wdata & 32'hFF0F_FFFF) | 32'h0080_0000;
                    32'h1008: mreg[off] = (wdata & 32'h801F_000F) | 32'h1;
                    32'h1010, 32'h1014, 32'h1018, 32'h101C:
                        mreg[off] = wdata & 32'h0001_0003;
                    32'h2000: mreg[off] = (wdata & 32'h001F_0000) | 32'h8;
                    32'h3018: mreg[off] = mreg[off] | (wdata & 32'h00FF_FFFF);
                    default: ;
                endcase
            end
            if ((wr || rd) && (off == 32'h1000 || off == 32'h1004)) mirq = 0;
            if (fs) begin
                mreg[32'h1000] = fstat | 32'h0080_0000;
                mreg[32'h1004] = faddr;
                mirq = 1;
            end
        end
    end

    // ---------------- checking ----------------
    string tag = "R1";

    task automatic cmp(string t, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", t, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp(tag, "irq", 32'(irq), 32'(mirq));
        cmp(tag, "xlate_enable", 32'(xen), 32'(mreg[0][0]));
        cmp(tag, "xlate_base", xbase, mreg[4]);
        cmp(tag, "win_start", wstart, mwin);
    endtask

    // One cycle of bus activity; rdata compared against pre-edge model state
    task automatic step(string t, logic w, logic r, int a, logic [31:0] d,
                        logic f = 1'b0, logic [31:0] fsv = 0, logic [31:0] fav = 0);
        @(negedge clk);
        check_outputs();
        tag = t;
        wr = w; rd = r; addr = 14'(a); wdata = d;
        fs = f; fstat = fsv; faddr = fav;
        #1;
        if (r) cmp(t, $sformatf("rdata@%04h", a), rdata, mread(a));
    endtask

    task automatic rd_word(string t, int a);
        step(t, 1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic wr_word(string t, int a, logic [31:0] d);
        step(t, 1'b1, 1'b0, a, d);
    endtask

    int impl_offs[15] = '{32'h0, 32'h4, 32'h14, 32'h18, 32'h1000, 32'h1004, 32'h1008,
                          32'h1010, 32'h1014, 32'h1018, 32'h101C, 32'h2000, 32'h3018,
                          32'h0008, 32'h1020};

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values via reads
        for (int k = 0; k < 13; k++) rd_word("R1", impl_offs[k]);

        // R2/R9: control and flush registers, all-ones and zeros
        wr_word("R2", 32'h0000, 32'hFFFF_FFFF); rd_word("R2", 32'h0000);
        wr_word("R2", 32'h0000, 32'h0000_0000); rd_word("R2", 32'h0000);
        wr_word("R9", 32'h0014, 32'hDEAD_BEEF); rd_word("R9", 32'h0014);
        wr_word("R9", 32'h0018, 32'h1234_5678); rd_word("R9", 32'h0018);

        // R3: every size code
        for (int n = 0; n < 8; n++) wr_word("R3", 32'h0000, 32'(n << 2) | 32'h1);
        rd_word("R3", 32'h0004);

        // R4: base mask
        wr_word("R4", 32'h0004, 32'hFFFF_FFFF); rd_word("R4", 32'h0004);

        // R5: arbiter enable and slots
        wr_word("R5", 32'h1008, 32'hFFFF_FFFF); rd_word("R5", 32'h1008);
        wr_word("R5", 32'h1008, 32'h0);         rd_word("R5", 32'h1008);
        for (int k = 0; k < 4; k++) begin
            wr_word("R5", 32'h1010 + 4*k, 32'hFFFF_FFF0 | 32'(k));
            rd_word("R5", 32'h1010 + 4*k);
        end

        // R8: arbitration enable and mask-ID OR behaviour
        wr_word("R8", 32'h2000, 32'hFFFF_FFFF); rd_word("R8", 32'h2000);
        wr_word("R8", 32'h3018, 32'h0000_00F0);
        wr_word("R8", 32'h3018, 32'hFF00_0F00); rd_word("R8", 32'h3018);
        wr_word("R8", 32'h3018, 32'h0);         rd_word("R8", 32'h3018);

        // R10: fault capture, alone, then against write and read clears
        step("R10", 1'b0, 1'b0, 0, 0, 1'b1, 32'h4000_0000, 32'hCAFE_0000);
        rd_word("R7", 32'h1000);
        rd_word("R7", 32'h1004);
        step("R10", 1'b0, 1'b0, 0, 0, 1'b1, 32'h0, 32'h0000_1000);
        wr_word("R6", 32'h1000, 32'hFFFF_FFFF); rd_word("R6", 32'h1000);
        step("R10", 1'b0, 1'b0, 0, 0, 1'b1, 32'h0, 32'h0);
        wr_word("R6", 32'h1004, 32'hA5A5_5A5A); rd_word("R6", 32'h1004);
        step("R10", 1'b1, 1'b0, 32'h1000, 32'h0, 1'b1, 32'h2000_0000, 32'h55);
        rd_word("R10", 32'h1004);
        step("R10", 1'b0, 1'b1, 32'h1000, 32'h0, 1'b1, 32'h1000_0000, 32'h66);
        step("R10", 1'b0, 1'b0, 0, 0);
        rd_word("R7", 32'h1000);

        // R11/R12: unimplemented offsets and aliasing
        wr_word("R11", 32'h0008, 32'hFFFF_FFFF); rd_word("R11", 32'h0008);
        wr_word("R11", 32'h1020, 32'hFFFF_FFFF); rd_word("R11", 32'h1020);
        wr_word("R11", 32'h3FFC, 32'hFFFF_FFFF); rd_word("R11", 32'h3FFC);
        wr_word("R12", 32'h2004, 32'hFFFF_FFFF); rd_word("R12", 32'h2000);
        rd_word("R12", 32'h000C);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int a;
            logic w, r, f;
            a = impl_offs[$urandom_range(0, 14)];
            w = 1'($urandom_range(0, 1));
            r = ($urandom_range(0, 2) == 0);
            f = ($urandom_range(0, 7) == 0);
            step("R12", w, r, a, $urandom(), f, $urandom(), $urandom());
        end
        step("R12", 1'b0, 1'b0, 0, 0);
        @(negedge clk);
        check_outputs();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule